// File: doc/BRIEF.md
# One-Shot and Periodic Tick Timers

This block holds two 32-bit timers behind a word-wide register port. One is a one-shot countdown. The other is a periodic timer that reloads itself. Time is measured in ticks: a shared 32-bit time base advances only on clock cycles where `tick_i` is high, and it wraps modulo 2^32. Software arms a timer by writing a tick count N to its control register. The timer's event output then pulses on the N-th tick after the write. Writing zero cancels the timer.

Each timer keeps the time base value from its last arm (its start) together with N. The remaining-tick register is therefore computed as start + N − now, and no separate down-counter is kept. When the periodic timer expires it moves its start to the current time and runs for another N ticks. When the countdown expires it disarms, and it stays disarmed until it is written again. Register values are big-endian: the byte at the lowest address is the most significant byte. Only whole 4-byte accesses are accepted.

Top module: `tick_timer_pair`

## Requirements
- R1: The register offsets are as follows.
  - 32: countdown control, read/write.
  - 36: countdown remaining, read-only.
  - 40: periodic control, read/write.
  - 44: periodic remaining, read-only.
  
  Data lane k (bits 8k+7:8k of the data buses) carries the byte at offset k. A register value is taken big-endian, with lane 0 as the most significant byte. For example, the value 20 travels as 32'h1400_0000.
- R2: After reset every register reads 0. A control register reads back the last value written to it, including after the timer has expired.
- R3: Writing a nonzero N to a control register arms that timer. Its event output is high in exactly the cycle of the N-th `tick_i` cycle after the write cycle, and only for that cycle. A tick that falls in the write cycle itself is not counted.
- R4: Writing 0 to a control register disarms that timer. After that it produces no event, and its remaining register reads 0.
- R5: A nonzero write to an armed timer cancels the pending expiry and counts N ticks again from the new write.
- R6: The countdown fires once. After it expires it produces no further events, and its remaining register reads 0 until it is written again.
- R7: The periodic timer fires on every N-th tick for as long as it stays armed. Right after an expiry its remaining register reads N.
- R8: While a timer is armed, its remaining register reads N minus the ticks seen since the write. Cycles without `tick_i` do not change it.
- R9: An access of any size other than 4 bytes (`req_size_i` != 4) to one of the four offsets raises `rsp_err_o` in that cycle. That access does not change any state, and its read data is 0.
- R10: Writes to the remaining registers and to unmapped offsets are ignored and raise no error. Reads of unmapped offsets return 0.
- R11: The time base wraps modulo 2^32. A timer whose window crosses the wrap still counts correctly. The time base's reset value is the parameter `TIME_INIT`.
- R12: The two timers run independently when both are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable; the time base advances in cycles where this is high |
| req_valid_i | input | 1 | Access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, byte lane k = offset k |
| rsp_rdata_o | output | 32 | Read data in the same cycle, same lane layout |
| rsp_err_o | output | 1 | Access size error |
| cd_event_o | output | 1 | Countdown expiry pulse |
| per_event_o | output | 1 | Periodic expiry pulse |

## Verification
The timers are exercised with several tick patterns. Back-to-back ticks give the exact expiry cycle. Idle cycles between ticks show that only ticks count, not clocks. A tick in the same cycle as the write shows that the arming cycle is excluded.

The time base starts 16 ticks short of its wrap, so the first countdown crosses zero. This shows the difference between modular and plain comparison.

The bench also covers rewrites in mid-count, zero writes, wrong-size accesses and writes to read-only offsets. Each of these is checked against the event outputs and the register readback, which separates a cancelled expiry from a lost one. Running both timers together with different periods shows that they do not interfere.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned N_TMR  = 2;

  localparam logic [ADDR_W-1:0] OFS_CD_CTRL  = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] OFS_CD_LEFT  = ADDR_W'(36);
  localparam logic [ADDR_W-1:0] OFS_PER_CTRL = ADDR_W'(40);
  localparam logic [ADDR_W-1:0] OFS_PER_LEFT = ADDR_W'(44);
  localparam logic [SIZE_W-1:0] WORD_BYTES   = SIZE_W'(NBYTES);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CD_CTRL,
    SEL_CD_LEFT,
    SEL_PER_CTRL,
    SEL_PER_LEFT
  } reg_sel_e;

  // lane k holds offset k; value is big-endian (offset 0 = MSB)
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < int'(NBYTES); k++) begin
      r[8*k +: 8] = d[8*(int'(NBYTES)-1-k) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
  import tt_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output reg_sel_e          sel_o,
  output logic              err_o,
  output logic [N_TMR-1:0]  wr_o
);
  reg_sel_e hit;
  logic     size_ok;

  always_comb begin
    case (addr_i)
      OFS_CD_CTRL:  hit = SEL_CD_CTRL;
      OFS_CD_LEFT:  hit = SEL_CD_LEFT;
      OFS_PER_CTRL: hit = SEL_PER_CTRL;
      OFS_PER_LEFT: hit = SEL_PER_LEFT;
      default:      hit = SEL_NONE;
    endcase
    size_ok = (size_i == WORD_BYTES);
    err_o   = valid_i && (hit != SEL_NONE) && !size_ok;
    sel_o   = (valid_i && size_ok) ? hit : SEL_NONE;
    wr_o[0] = write_i && (sel_o == SEL_CD_CTRL);
    wr_o[1] = write_i && (sel_o == SEL_PER_CTRL);
  end
endmodule

// File: rtl/tt_tick_base.sv
module tt_tick_base
  import tt_pkg::*;
#(
  parameter logic [DATA_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [DATA_W-1:0] now_o,
  output logic [DATA_W-1:0] now_nxt_o
);
  logic [DATA_W-1:0] now_q;

  assign now_nxt_o = now_q + {{(DATA_W-1){1'b0}}, tick_i};
  assign now_o     = now_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= INIT;
    else         now_q <= now_nxt_o;
  end
endmodule

// File: rtl/tt_timer_unit.sv
module tt_timer_unit
  import tt_pkg::*;
#(
  parameter bit PERIODIC = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] now_i,
  input  logic [DATA_W-1:0] now_nxt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wval_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] left_o,
  output logic              event_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              armed_q;
  logic [DATA_W-1:0] delta_q;
  logic [DATA_W-1:0] start_q;
  logic              expire;
  logic              stay_armed;

  generate
    if (PERIODIC) begin : g_reload
      assign stay_armed = 1'b1;
    end else begin : g_oneshot
      assign stay_armed = 1'b0;
    end
  endgenerate

  // modular difference stays correct across time base wrap
  assign left_o  = armed_q ? (start_q + delta_q - now_i) : '0;
  assign expire  = armed_q && tick_i && !wr_i && (left_o == ONE);
  assign event_o = expire;
  assign ctrl_o  = delta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      delta_q <= '0;
      start_q <= '0;
    end else if (wr_i) begin
      delta_q <= wval_i;
      start_q <= now_nxt_i;
      armed_q <= (wval_i != '0);
    end else if (expire) begin
      start_q <= now_nxt_i;
      armed_q <= stay_armed;
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tt_pkg::*;
#(
  parameter logic [DATA_W-1:0] TIME_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              cd_event_o,
  output logic              per_event_o
);
  reg_sel_e                     sel;
  logic [N_TMR-1:0]             wr;
  logic [N_TMR-1:0]             ev;
  logic [N_TMR-1:0][DATA_W-1:0] ctrl_val;
  logic [N_TMR-1:0][DATA_W-1:0] left_val;
  logic [DATA_W-1:0]            now;
  logic [DATA_W-1:0]            now_nxt;
  logic [DATA_W-1:0]            wval;

  assign wval = lane_swap(req_wdata_i);

  tt_bus_decode u_dec (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .sel_o   (sel),
    .err_o   (rsp_err_o),
    .wr_o    (wr)
  );

  tt_tick_base #(.INIT(TIME_INIT)) u_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .now_o     (now),
    .now_nxt_o (now_nxt)
  );

  // index 0: one-shot, index 1: periodic
  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tt_timer_unit #(.PERIODIC(t == 1)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .now_i     (now),
      .now_nxt_i (now_nxt),
      .wr_i      (wr[t]),
      .wval_i    (wval),
      .ctrl_o    (ctrl_val[t]),
      .left_o    (left_val[t]),
      .event_o   (ev[t])
    );
  end

  assign cd_event_o  = ev[0];
  assign per_event_o = ev[1];

  always_comb begin
    rsp_rdata_o = '0;
    if (!req_write_i) begin
      case (sel)
        SEL_CD_CTRL:  rsp_rdata_o = lane_swap(ctrl_val[0]);
        SEL_CD_LEFT:  rsp_rdata_o = lane_swap(left_val[0]);
        SEL_PER_CTRL: rsp_rdata_o = lane_swap(ctrl_val[1]);
        SEL_PER_LEFT: rsp_rdata_o = lane_swap(left_val[1]);
        default:      rsp_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk
  import tt_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     tick_i,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic [ADDR_W-1:0]        req_addr_i,
  input logic [SIZE_W-1:0]        req_size_i,
  input logic [DATA_W-1:0]        req_wdata_i,
  input logic                     rsp_err_o,
  input logic                     cd_event_o,
  input logic                     per_event_o,
  input logic [N_TMR-1:0][DATA_W-1:0] ctrl_i
);
  logic wr_ok;
  assign wr_ok = req_valid_i && req_write_i && (req_size_i == WORD_BYTES);

  // R3
  cd_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_event_o |-> tick_i);

  // R7
  per_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_event_o |-> tick_i);

  // R6
  cd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_event_o |=> !cd_event_o);

  // R9
  err_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> req_valid_i);

  // R9
  err_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |=> $stable(ctrl_i));

  // R4
  zero_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && req_addr_i == OFS_CD_CTRL && req_wdata_i == '0) |=> !cd_event_o);

  // R3
  cd_one_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && req_addr_i == OFS_CD_CTRL && req_wdata_i == 32'h0100_0000)
    |=> ((req_valid_i && req_write_i && req_addr_i == OFS_CD_CTRL) || (cd_event_o == tick_i)));

  // R7
  per_one_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && req_addr_i == OFS_PER_CTRL && req_wdata_i == 32'h0100_0000)
    |=> ((req_valid_i && req_write_i && req_addr_i == OFS_PER_CTRL) || (per_event_o == tick_i)));
endmodule

bind tick_timer_pair tt_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .req_wdata_i (req_wdata_i),
  .rsp_err_o   (rsp_err_o),
  .cd_event_o  (cd_event_o),
  .per_event_o (per_event_o),
  .ctrl_i      (ctrl_val)
);

// File: tb/tb_tick_timer_pair.sv
module tb_tick_timer_pair;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] T0 = 32'hFFFF_FFF0;
  localparam logic [5:0] A_CD = 6'd32, A_CDL = 6'd36, A_PER = 6'd40, A_PERL = 6'd44;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic rsp_err, cd_ev, per_ev;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_pair #(.TIME_INIT(T0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .cd_event_o(cd_ev), .per_event_o(per_ev)
  );

  function automatic logic [31:0] be(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs change 1 time unit after a rising edge, outputs sampled at the falling edge
  task automatic bus_write(input string req, input logic [5:0] a, input logic [2:0] sz,
                           input logic [31:0] v, input logic tk, input logic exp_err);
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = be(v); tick = tk;
    @(negedge clk);
    check(req, "write err", {31'd0, rsp_err}, {31'd0, exp_err});
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; req_size = 3'd4; tick = 0;
  endtask

  task automatic bus_read(input string req, input logic [5:0] a, input logic [2:0] sz,
                          input logic [31:0] exp_val, input logic exp_err);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz; tick = 0;
    @(negedge clk);
    check(req, "read data", rsp_rdata, be(exp_val));
    check(req, "read err", {31'd0, rsp_err}, {31'd0, exp_err});
    @(posedge clk); #1;
    req_valid = 0; req_size = 3'd4;
  endtask

  // n tick cycles; cd expected on tick cd_at (0 = never), per on multiples of per_n (0 = never)
  task automatic run_ticks(input string req, input int n, input int cd_at, input int per_n);
    for (int i = 1; i <= n; i++) begin
      tick = 1;
      @(negedge clk);
      check(req, $sformatf("cd event tick %0d", i), {31'd0, cd_ev}, {31'd0, (i == cd_at)});
      check(req, $sformatf("per event tick %0d", i), {31'd0, per_ev},
            {31'd0, (per_n != 0) && (i % per_n == 0)});
      @(posedge clk); #1;
      tick = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8", "no event idle", {30'd0, cd_ev, per_ev}, 32'd0);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset;
    check("R2", "cd event at reset", {31'd0, cd_ev}, 32'd0);
    check("R2", "per event at reset", {31'd0, per_ev}, 32'd0);
    bus_read("R2", A_CD, 3'd4, 0, 0);
    bus_read("R2", A_CDL, 3'd4, 0, 0);
    bus_read("R2", A_PER, 3'd4, 0, 0);
    bus_read("R2", A_PERL, 3'd4, 0, 0);
    bus_read("R10", 6'd48, 3'd4, 0, 0);
  endtask

  task automatic t_wrap_countdown;
    bus_write("R3", A_CD, 3'd4, 20, 0, 0);
    // R1 raw lane layout
    req_valid = 1; req_write = 0; req_addr = A_CD; req_size = 3'd4;
    @(negedge clk);
    check("R1", "raw lanes", rsp_rdata, 32'h1400_0000);
    @(posedge clk); #1; req_valid = 0;
    bus_read("R8", A_CDL, 3'd4, 20, 0);
    run_ticks("R11", 18, 0, 0);
    bus_read("R11", A_CDL, 3'd4, 2, 0);
    run_ticks("R3", 2, 2, 0);
    run_ticks("R6", 5, 0, 0);
    bus_read("R6", A_CDL, 3'd4, 0, 0);
    bus_read("R2", A_CD, 3'd4, 20, 0);
  endtask

  task automatic t_tick_on_write;
    bus_write("R3", A_CD, 3'd4, 2, 1, 0);
    run_ticks("R3", 3, 2, 0);
  endtask

  task automatic t_rearm;
    bus_write("R5", A_CD, 3'd4, 10, 0, 0);
    run_ticks("R5", 4, 0, 0);
    bus_write("R5", A_CD, 3'd4, 3, 0, 0);
    run_ticks("R5", 8, 3, 0);
  endtask

  task automatic t_disarm;
    bus_write("R4", A_CD, 3'd4, 10, 0, 0);
    run_ticks("R4", 2, 0, 0);
    bus_write("R4", A_CD, 3'd4, 0, 0, 0);
    run_ticks("R4", 15, 0, 0);
    bus_read("R4", A_CDL, 3'd4, 0, 0);
    bus_read("R4", A_CD, 3'd4, 0, 0);
  endtask

  task automatic t_idle_cycles;
    bus_write("R8", A_CD, 3'd4, 6, 0, 0);
    run_ticks("R8", 2, 0, 0);
    idle(5);
    bus_read("R8", A_CDL, 3'd4, 4, 0);
  endtask

  task automatic t_size_err;
    bus_write("R9", A_CD, 3'd2, 9, 0, 1);
    bus_read("R9", A_CD, 3'd4, 6, 0);
    bus_read("R9", A_CDL, 3'd4, 4, 0);
    bus_read("R9", A_CD, 3'd1, 0, 1);
    bus_write("R9", A_PER, 3'd1, 5, 0, 1);
    bus_read("R9", A_PER, 3'd4, 0, 0);
    bus_write("R4", A_CD, 3'd4, 0, 0, 0);
  endtask

  task automatic t_readonly;
    bus_write("R10", A_CDL, 3'd4, 7, 0, 0);
    bus_write("R10", 6'd48, 3'd4, 7, 0, 0);
    bus_read("R10", A_CD, 3'd4, 0, 0);
    bus_read("R10", A_CDL, 3'd4, 0, 0);
    run_ticks("R10", 10, 0, 0);
  endtask

  task automatic t_periodic;
    bus_write("R7", A_PER, 3'd4, 3, 0, 0);
    run_ticks("R7", 9, 0, 3);
    bus_read("R7", A_PERL, 3'd4, 3, 0);
    run_ticks("R7", 1, 0, 0);
    bus_read("R7", A_PERL, 3'd4, 2, 0);
    bus_read("R2", A_PER, 3'd4, 3, 0);
  endtask

  task automatic t_both;
    bus_write("R12", A_CD, 3'd4, 4, 0, 0);
    bus_write("R12", A_PER, 3'd4, 2, 0, 0);
    run_ticks("R12", 6, 4, 2);
    bus_write("R4", A_PER, 3'd4, 0, 0, 0);
    run_ticks("R4", 4, 0, 0);
    bus_read("R4", A_PERL, 3'd4, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_wrap_countdown();
    t_tick_on_write();
    t_rearm();
    t_disarm();
    t_idle_cycles();
    t_size_err();
    t_readonly();
    t_periodic();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule